// File: doc/BRIEF.md
# Colour Look-Up Table Register Interface

This block holds the colour table of a display controller. A bus writes or reads one 32-bit word per access and sees a 16-byte register window. The table has 256 pseudocolour entries and four overlay entries, and each entry holds an 8-bit red, an 8-bit green and an 8-bit blue component. Overlay entries 2 and 3 (entries 258 and 259) are the two cursor colours.

Software first writes a colour number to the index register. It then sends the components one after another through a data register, always in the order red, green, blue. A phase counter inside the block tracks which component comes next. When the blue component has been transferred, the index steps to the next entry, so a whole range of the table can be loaded or dumped without rewriting the index. A second data register reaches the overlay entries through the two low bits of the same index.

A separate lookup port serves the display pipeline. It takes an entry number and returns that entry's 24-bit colour one clock later. The two cursor colours are also driven on outputs of their own at all times.

Top module: `clut_regif`

## Requirements
- R1: After reset every component is zero, except entries 255, 256 and 258, which read 0xFFFFFF. The index is 0 and the phase is red.
- R2: A write at byte offset 0 (bus_addr[3:2]=0) loads the index from bus_wdata[31:24] and sets the phase back to red.
- R3: A write at offset 4 (bus_addr[3:2]=1) stores bus_wdata[31:24] into the current component of pseudocolour entry index. Successive writes go to red, then green, then blue. In the packed colour, red is bits 23:16, green 15:8 and blue 7:0.
- R4: Completing the blue component steps the index by one, modulo 256, and returns the phase to red.
- R5: A write at offset 12 (bus_addr[3:2]=3) stores into overlay entry 256 + index[1:0]. It uses the same component order and the same index step after blue.
- R6: A read at any offset returns the current component of pseudocolour entry index in bus_rdata[31:24], with zeros in bits 23:0. The data is valid in the cycle after the read request. A read advances the phase and the index exactly as a data write does.
- R7: A write at offset 8 (bus_addr[3:2]=2) changes neither the table, nor the index, nor the phase.
- R8: lk_ent selects any of the 260 entries. lk_rgb shows that entry's colour on the clock edge after lk_ent is presented. An entry number of 260 or more returns zero.
- R9: cur_col0 always shows entry 258 and cur_col1 always shows entry 259.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data; bits 31:24 are used |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| lk_ent | input | 9 | Entry number for the display lookup |
| lk_rgb | output | 24 | Colour of the looked-up entry, {R,G,B} |
| cur_col0 | output | 24 | First cursor colour (entry 258) |
| cur_col1 | output | 24 | Second cursor colour (entry 259) |

## Verification
The bench builds the block with its default parameters: an 8-bit index, four overlay entries, 8-bit components and a registered lookup. With these values the index wrap from 255 to 0 takes only a few accesses. The overlay aliasing through index[1:0] can be reached from any index, and the reset pattern at entries 255, 256 and 258 sits next to ordinary zero entries, so the lookup port can compare them directly. Lookup numbers from 260 up to the top of the 9-bit range can also be reached, which exercises the out-of-range case.

// File: rtl/clut_pkg.sv
`timescale 1ns/1ps
package clut_pkg;

   // Component phase of the data port; the sequence is red, green, blue.
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } clut_phase_e;

   // Register words inside the window, selected by bus_addr[3:2].
   localparam logic [1:0] WORD_INDEX = 2'd0;
   localparam logic [1:0] WORD_PIXEL = 2'd1;
   localparam logic [1:0] WORD_SPARE = 2'd2;
   localparam logic [1:0] WORD_OVLAY = 2'd3;

endpackage

// File: rtl/clut_seq.sv
`timescale 1ns/1ps
module clut_seq
   import clut_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic             step_en,
   output logic [IDX_W-1:0] idx_q,
   output clut_phase_e      ph_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         ph_q  <= PH_RED;
      end else if (ld_en) begin
         idx_q <= ld_idx;
         ph_q  <= PH_RED;
      end else if (step_en) begin
         unique case (ph_q)
            PH_RED:  ph_q <= PH_GRN;
            PH_GRN:  ph_q <= PH_BLU;
            default: begin
               ph_q  <= PH_RED;
               idx_q <= idx_q + 1'b1;
            end
         endcase
      end
   end

   AST_LOAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (idx_q == $past(ld_idx)) && (ph_q == PH_RED)) else $error("load"); // R2

   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_en && ph_q == PH_BLU) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (ph_q == PH_RED)) else $error("wrap"); // R4

   AST_MID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_en && ph_q != PH_BLU) |=> $stable(idx_q)) else $error("mid"); // R3

endmodule

// File: rtl/clut_store.sv
`timescale 1ns/1ps
module clut_store
   import clut_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter int OVL_N      = 4,
   parameter int COMP_W     = 8,
   parameter bit LOOKUP_REG = 1'b1,
   localparam int BASE_N    = 1 << IDX_W,
   localparam int ENT_N     = BASE_N + OVL_N,
   localparam int ENT_W     = $clog2(ENT_N),
   localparam int RGB_W     = 3 * COMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ENT_W-1:0]  wr_ent,
   input  clut_phase_e       wr_ph,
   input  logic [COMP_W-1:0] wr_byte,
   input  logic [ENT_W-1:0]  rd_ent,
   input  clut_phase_e       rd_ph,
   output logic [COMP_W-1:0] rd_byte,
   input  logic [ENT_W-1:0]  lk_ent,
   output logic [RGB_W-1:0]  lk_rgb,
   output logic [RGB_W-1:0]  cur0,
   output logic [RGB_W-1:0]  cur1
);

   logic [RGB_W-1:0] ent_w [ENT_N];

   for (genvar e = 0; e < ENT_N; e++) begin : g_ent
      localparam bit WHITE = (e == BASE_N - 1) || (e == BASE_N) || (e == BASE_N + 2);
      localparam logic [RGB_W-1:0] RST_VAL = WHITE ? {RGB_W{1'b1}} : '0;
      logic [RGB_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RST_VAL;
         end else if (wr_en && wr_ent == ENT_W'(e)) begin
            unique case (wr_ph)
               PH_RED:  q[3*COMP_W-1 -: COMP_W] <= wr_byte;
               PH_GRN:  q[2*COMP_W-1 -: COMP_W] <= wr_byte;
               default: q[COMP_W-1   -: COMP_W] <= wr_byte;
            endcase
         end
      end
      assign ent_w[e] = q;
   end

   // Bus read: one component of the selected entry.
   logic [RGB_W-1:0] rd_ent_val;
   always_comb begin
      rd_ent_val = (32'(rd_ent) < ENT_N) ? ent_w[rd_ent] : '0;
      unique case (rd_ph)
         PH_RED:  rd_byte = rd_ent_val[3*COMP_W-1 -: COMP_W];
         PH_GRN:  rd_byte = rd_ent_val[2*COMP_W-1 -: COMP_W];
         default: rd_byte = rd_ent_val[COMP_W-1   -: COMP_W];
      endcase
   end

   // Display lookup, out-of-range numbers give zero.
   logic [RGB_W-1:0] lk_val;
   assign lk_val = (32'(lk_ent) < ENT_N) ? ent_w[lk_ent] : '0;

   if (LOOKUP_REG) begin : g_lk_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lk_rgb <= '0;
         else        lk_rgb <= lk_val;
      end
   end else begin : g_lk_comb
      assign lk_rgb = lk_val;
   end

   assign cur0 = ent_w[BASE_N + 2];
   assign cur1 = ent_w[BASE_N + 3];

   AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cur0) && $stable(cur1)) else $error("cursor"); // R9

endmodule

// File: rtl/clut_regif.sv
`timescale 1ns/1ps
module clut_regif
   import clut_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter int OVL_N      = 4,
   parameter int COMP_W     = 8,
   parameter int DATA_W     = 32,
   parameter bit LOOKUP_REG = 1'b1,
   localparam int BASE_N    = 1 << IDX_W,
   localparam int ENT_N     = BASE_N + OVL_N,
   localparam int ENT_W     = $clog2(ENT_N),
   localparam int RGB_W     = 3 * COMP_W,
   localparam int OVL_W     = $clog2(OVL_N),
   localparam int OFF_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [OFF_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [ENT_W-1:0]  lk_ent,
   output logic [RGB_W-1:0]  lk_rgb,
   output logic [RGB_W-1:0]  cur_col0,
   output logic [RGB_W-1:0]  cur_col1
);

   if (COMP_W > DATA_W || IDX_W > DATA_W) begin : g_bad_width
      $error("component and index must fit in the data word");
   end
   if (OVL_N < 4 || (1 << OVL_W) != OVL_N) begin : g_bad_ovl
      $error("overlay count must be a power of two, at least 4");
   end

   logic [1:0]        word;
   logic              acc_wr, acc_rd, ld_en, step_en, pix_wr, ovl_wr;
   logic [IDX_W-1:0]  idx_q;
   clut_phase_e       ph_q;
   logic [ENT_W-1:0]  wr_ent;
   logic [COMP_W-1:0] rd_byte;

   assign word    = bus_addr[3:2];
   assign acc_wr  = bus_valid && bus_write;
   assign acc_rd  = bus_valid && !bus_write;
   assign ld_en   = acc_wr && (word == WORD_INDEX);
   assign pix_wr  = acc_wr && (word == WORD_PIXEL);
   assign ovl_wr  = acc_wr && (word == WORD_OVLAY);
   assign step_en = pix_wr || ovl_wr || acc_rd;
   assign wr_ent  = ovl_wr ? ENT_W'(BASE_N + 32'(idx_q[OVL_W-1:0])) : ENT_W'(idx_q);

   clut_seq #(.IDX_W(IDX_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_idx  (bus_wdata[DATA_W-1 -: IDX_W]),
      .step_en (step_en),
      .idx_q   (idx_q),
      .ph_q    (ph_q)
   );

   clut_store #(
      .IDX_W      (IDX_W),
      .OVL_N      (OVL_N),
      .COMP_W     (COMP_W),
      .LOOKUP_REG (LOOKUP_REG)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pix_wr || ovl_wr),
      .wr_ent  (wr_ent),
      .wr_ph   (ph_q),
      .wr_byte (bus_wdata[DATA_W-1 -: COMP_W]),
      .rd_ent  (ENT_W'(idx_q)),
      .rd_ph   (ph_q),
      .rd_byte (rd_byte),
      .lk_ent  (lk_ent),
      .lk_rgb  (lk_rgb),
      .cur0    (cur_col0),
      .cur1    (cur_col1)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (acc_rd) bus_rdata <= {rd_byte, {(DATA_W-COMP_W){1'b0}}};
      else             bus_rdata <= '0;
   end

   AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && word == WORD_SPARE) |=> $stable(idx_q) && $stable(ph_q)) else $error("spare"); // R7

   AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd |=> (bus_rdata[DATA_W-COMP_W-1:0] == '0)) else $error("rdata"); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> $stable(idx_q) && $stable(ph_q) && (bus_rdata == '0)) else $error("idle"); // R6

endmodule

// File: tb/clut_regif_bench.sv
`timescale 1ns/1ps
module clut_regif_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [8:0]  lk_ent = '0;
   logic [23:0] lk_rgb;
   logic [23:0] cur_col0, cur_col1;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clut_regif u_clut_regif (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .lk_ent(lk_ent), .lk_rgb(lk_rgb), .cur_col0(cur_col0), .cur_col1(cur_col1)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = {d, 24'h5A5A5A};
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'h4;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic look(input logic [8:0] e, output logic [23:0] c);
      @(negedge clk);
      lk_ent = e;
      @(negedge clk);
      c = lk_rgb;
   endtask

   task automatic t_reset();
      logic [23:0] c;
      logic [31:0] d;
      look(9'd0, c);   chk("R1 entry 0", 32'(c), 32'h0);
      look(9'd255, c); chk("R1 entry 255", 32'(c), 32'hFFFFFF);
      look(9'd256, c); chk("R1 entry 256", 32'(c), 32'hFFFFFF);
      look(9'd257, c); chk("R1 entry 257", 32'(c), 32'h0);
      look(9'd258, c); chk("R1 entry 258", 32'(c), 32'hFFFFFF);
      look(9'd259, c); chk("R1 entry 259", 32'(c), 32'h0);
      chk("R9 cursor 0 at reset", 32'(cur_col0), 32'hFFFFFF);
      chk("R9 cursor 1 at reset", 32'(cur_col1), 32'h0);
      rd(d); chk("R1 index 0 red read", d, 32'h0);
      wr(4'h0, 8'd0);
   endtask

   task automatic t_triple();
      logic [23:0] c;
      wr(4'h0, 8'd10);
      wr(4'h4, 8'h11); wr(4'h4, 8'h22); wr(4'h4, 8'h33);
      look(9'd10, c); chk("R3 triple order", 32'(c), 32'h112233);
      wr(4'h4, 8'h44);
      look(9'd11, c); chk("R4 step to next entry", 32'(c), 32'h440000);
   endtask

   task automatic t_wrap();
      logic [23:0] c;
      wr(4'h0, 8'd255);
      wr(4'h4, 8'hAA); wr(4'h4, 8'hBB); wr(4'h4, 8'hCC);
      look(9'd255, c); chk("R3 entry 255", 32'(c), 32'hAABBCC);
      wr(4'h4, 8'h01);
      look(9'd0, c); chk("R4 wrap to entry 0", 32'(c), 32'h010000);
   endtask

   task automatic t_reload();
      logic [23:0] c;
      wr(4'h0, 8'd20);
      wr(4'h4, 8'h55);
      wr(4'h0, 8'd20);
      wr(4'h4, 8'h66);
      look(9'd20, c); chk("R2 reload resets phase", 32'(c), 32'h660000);
   endtask

   task automatic t_overlay();
      logic [23:0] c;
      wr(4'h0, 8'd6);
      wr(4'hC, 8'h12); wr(4'hC, 8'h34); wr(4'hC, 8'h56);
      look(9'd258, c); chk("R5 overlay via index low bits", 32'(c), 32'h123456);
      chk("R9 cursor 0", 32'(cur_col0), 32'h123456);
      look(9'd6, c); chk("R5 base entry untouched", 32'(c), 32'h0);
      wr(4'hC, 8'h78);
      chk("R5 overlay index stepped", 32'(cur_col1), 32'h780000);
   endtask

   task automatic t_read();
      logic [31:0] d;
      logic [23:0] c;
      wr(4'h0, 8'd10);
      rd(d); chk("R6 read red", d, 32'h11000000);
      rd(d); chk("R6 read green", d, 32'h22000000);
      rd(d); chk("R6 read blue", d, 32'h33000000);
      rd(d); chk("R6 read steps index", d, 32'h44000000);
      wr(4'h0, 8'd30);
      rd(d);
      wr(4'h4, 8'h99);
      look(9'd30, c); chk("R6 read advances phase", 32'(c), 32'h009900);
   endtask

   task automatic t_spare();
      logic [23:0] c;
      wr(4'h0, 8'd40);
      wr(4'h8, 8'hEE);
      wr(4'h4, 8'h77);
      look(9'd40, c); chk("R7 offset 8 ignored", 32'(c), 32'h770000);
      look(9'd41, c); chk("R7 index unchanged", 32'(c), 32'h0);
   endtask

   task automatic t_lookup_range();
      logic [23:0] c;
      look(9'd300, c); chk("R8 out of range 300", 32'(c), 32'h0);
      look(9'd511, c); chk("R8 out of range 511", 32'(c), 32'h0);
      @(negedge clk); lk_ent = 9'd10;
      chk("R8 not before the clock edge", 32'(lk_rgb), 32'h0);
      @(negedge clk);
      chk("R8 after the clock edge", 32'(lk_rgb), 32'h112233);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_triple();
      t_wrap();
      t_reload();
      t_overlay();
      t_read();
      t_spare();
      t_lookup_range();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

endmodule